// File: doc/BRIEF.md
# Multi-Lane Sync and Reinit Combiner

This block sits behind a four-lane serial receiver. Each lane reports its own synchronization request and its own reset indication. The block folds the four requests into one synchronization pin level and the four resets into one reinitialization request. A programmable selection mode decides how the lanes combine: any lane, all lanes, a lane pair, or a single lane. A mode can also force the result to a fixed value. The sync pin has a programmable active level.

The same block also inverts the 8-bit data of any lane whose polarity bit is set. The data-valid qualifier travels through the same register stage as the data, so the two stay aligned.

Two 8-bit control registers hold the configuration:

- a mode register at address 0Ch;
- a lane-polarity register at address 0Dh.

Software reaches them through a plain address/data port with a write enable. Read data is combinational. Every output (sync, reinit, lane data and valid) is registered, with a latency of one clock.

Top module: `lane_sync_combiner`

## Requirements
- R1: While reset is asserted and right after it, `syncOut` is 1, and `reinitOut`, `laneValidOut` and `laneDataOut` are 0. Both registers read 00h.
- R2: Address 0Ch holds the mode register. Bits 7:5 are the reinit selector, bit 4 is the sync level (1 = active high), and bits 3:0 are the sync selector. A write stores all 8 bits, and a read returns them.
- R3: Address 0Dh holds the lane-polarity register. Bit n controls lane n, for n = 0 to 3. Bits 7:4 always read 0, and writes to them are dropped.
- R4: A read from any address other than 0Ch or 0Dh returns 00h. A write to such an address changes neither register.
- R5: The reinit selector codes are:
  - 0 gives the OR of all four lane resets.
  - 1 gives the OR of lanes 0 and 1.
  - 2 gives the OR of lanes 2 and 3.
  - 3, 4, 5 and 6 follow the reset of lane 0, 1, 2 and 3 alone, in that order.
  - 7 holds reinit at 0.
- R6: The sync selector codes are:
  - 0 gives the OR of all four lanes.
  - 1 gives the AND of all four lanes.
  - 2 gives the OR of lanes 0 and 1.
  - 3 gives the AND of lanes 0 and 1.
  - 4 gives the OR of lanes 2 and 3.
  - 5 gives the AND of lanes 2 and 3.
  - 6, 7, 8 and 9 follow lane 0, 1, 2 and 3 alone, in that order.
  - 10 forces the selected value to 1.
  - 11 to 15 force it to 0.
- R7: The sync pin level equals the selected value when the sync-level bit is 1, and its inverse when the bit is 0. This also holds in the forced modes.
- R8: Lane n data sits at `laneDataIn[8n+7:8n]`. When polarity bit n is 1, all 8 bits of that lane are inverted at the output. When the bit is 0, the lane passes through unchanged.
- R9: Sync, reinit, lane data and valid change one clock edge after their inputs or the registers change, and not before. `laneValidOut` is `laneValidIn` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| laneSyncIn | input | 4 | Per-lane sync requests, active high |
| laneRstIn | input | 4 | Per-lane reset indications, active high |
| laneDataIn | input | 32 | Four 8-bit lane words, lane 0 in the low byte |
| laneValidIn | input | 1 | Qualifier for `laneDataIn` |
| laneDataOut | output | 32 | Lane words after polarity inversion |
| laneValidOut | output | 1 | Qualifier for `laneDataOut` |
| syncOut | output | 1 | Combined sync pin level |
| reinitOut | output | 1 | Combined reinitialization request, active high |

## Verification
The assertions assume that the register port is quiet or well defined whenever reset is released. They also assume that the lane inputs carry known values on every clock edge, since a pattern with unknown bits would make the pairing and forced-mode properties meaningless.

The stimulus meets these assumptions:

- It drives every input to a defined value from time zero.
- It changes inputs only on the falling clock edge.
- It makes register writes as single-cycle strobes.
- It sweeps each selector code against every one of the 16 lane patterns, and every mode runs under both sync levels.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int NUM_LANES = 4;
  localparam logic [7:0] MODE_ADDR = 8'h0C;
  localparam logic [7:0] POL_ADDR  = 8'h0D;

  typedef struct packed {
    logic [2:0]           reinitSel;
    logic                 syncActHigh;
    logic [3:0]           syncSel;
    logic [NUM_LANES-1:0] laneInv;
  } cfg_t;
endpackage

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output cfg_t              cfgOut
);
  localparam logic [ADDR_W-1:0] modeAddr = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] polAddr  = ADDR_W'(POL_ADDR);

  logic [7:0]           modeReg;
  logic [NUM_LANES-1:0] polReg;
  logic                 hitMode, hitPol;

  assign hitMode = (regAddr == modeAddr);
  assign hitPol  = (regAddr == polAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      polReg  <= '0;
    end else if (regWrEn) begin
      if (hitMode) modeReg <= regWrData[7:0];
      if (hitPol)  polReg  <= regWrData[NUM_LANES-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    if (hitMode)     regRdData[7:0]           = modeReg;
    else if (hitPol) regRdData[NUM_LANES-1:0] = polReg;
  end

  assign cfgOut.reinitSel   = modeReg[7:5];
  assign cfgOut.syncActHigh = modeReg[4];
  assign cfgOut.syncSel     = modeReg[3:0];
  assign cfgOut.laneInv     = polReg;

  // R2: a write to the mode address is visible after one edge
  a_r2_mode_store: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && hitMode) |=> (cfgOut.syncSel == $past(regWrData[3:0]) &&
                              cfgOut.reinitSel == $past(regWrData[7:5])));
  // R3: polarity write keeps only the lane bits
  a_r3_pol_store: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && hitPol) |=> (cfgOut.laneInv == $past(regWrData[3:0])));
  // R4: unmapped writes leave the configuration unchanged
  a_r4_unmapped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !hitMode && !hitPol) |=> $stable(cfgOut));
endmodule

// File: rtl/lsc_datapath.sv
module lsc_datapath
  import lsc_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cfg_t                          cfg,
  input  logic [NUM_LANES-1:0]          laneSyncIn,
  input  logic [NUM_LANES-1:0]          laneRstIn,
  input  logic [NUM_LANES*LANE_W-1:0]   laneDataIn,
  input  logic                          laneValidIn,
  output logic [NUM_LANES*LANE_W-1:0]   laneDataOut,
  output logic                          laneValidOut,
  output logic                          syncOut,
  output logic                          reinitOut
);
  logic selSync, selReinit;

  always_comb begin
    unique case (cfg.syncSel)
      4'd0:    selSync = |laneSyncIn;
      4'd1:    selSync = &laneSyncIn;
      4'd2:    selSync = laneSyncIn[0] | laneSyncIn[1];
      4'd3:    selSync = laneSyncIn[0] & laneSyncIn[1];
      4'd4:    selSync = laneSyncIn[2] | laneSyncIn[3];
      4'd5:    selSync = laneSyncIn[2] & laneSyncIn[3];
      4'd6:    selSync = laneSyncIn[0];
      4'd7:    selSync = laneSyncIn[1];
      4'd8:    selSync = laneSyncIn[2];
      4'd9:    selSync = laneSyncIn[3];
      4'd10:   selSync = 1'b1;
      default: selSync = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cfg.reinitSel)
      3'd0:    selReinit = |laneRstIn;
      3'd1:    selReinit = laneRstIn[0] | laneRstIn[1];
      3'd2:    selReinit = laneRstIn[2] | laneRstIn[3];
      3'd3:    selReinit = laneRstIn[0];
      3'd4:    selReinit = laneRstIn[1];
      3'd5:    selReinit = laneRstIn[2];
      3'd6:    selReinit = laneRstIn[3];
      default: selReinit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncOut      <= 1'b1;
      reinitOut    <= 1'b0;
      laneValidOut <= 1'b0;
    end else begin
      syncOut      <= selSync ^ ~cfg.syncActHigh;
      reinitOut    <= selReinit;
      laneValidOut <= laneValidIn;
    end
  end

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) laneDataOut[ln*LANE_W +: LANE_W] <= '0;
      else laneDataOut[ln*LANE_W +: LANE_W] <=
             laneDataIn[ln*LANE_W +: LANE_W] ^ {LANE_W{cfg.laneInv[ln]}};
    end
  end

  // R5: no lane reset means no reinit request
  a_r5_idle_no_reinit: assert property (@(posedge clk) disable iff (!rstN)
    (laneRstIn == '0) |=> !reinitOut);
  // R5: code 7 holds reinit low
  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.reinitSel == 3'd7) |=> !reinitOut);
  // R6/R7: all lanes active gives active level in every lane-derived mode
  a_r6_all_active: assert property (@(posedge clk) disable iff (!rstN)
    ((laneSyncIn == '1) && (cfg.syncSel <= 4'd9)) |=> (syncOut == $past(cfg.syncActHigh)));
  // R7: forced-one mode yields the active level
  a_r7_forced_one: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.syncSel == 4'd10) |=> (syncOut == $past(cfg.syncActHigh)));
  // R8: with no inversion a valid word passes through unchanged
  a_r8_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.laneInv == '0) |=> (laneDataOut == $past(laneDataIn)));
endmodule

// File: rtl/lane_sync_combiner.sv
module lane_sync_combiner
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [7:0]                  regWrData,
  output logic [7:0]                  regRdData,
  input  logic [NUM_LANES-1:0]        laneSyncIn,
  input  logic [NUM_LANES-1:0]        laneRstIn,
  input  logic [NUM_LANES*LANE_W-1:0] laneDataIn,
  input  logic                        laneValidIn,
  output logic [NUM_LANES*LANE_W-1:0] laneDataOut,
  output logic                        laneValidOut,
  output logic                        syncOut,
  output logic                        reinitOut
);
  cfg_t cfg;

  lsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cfgOut(cfg)
  );

  lsc_datapath #(.LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .laneSyncIn(laneSyncIn), .laneRstIn(laneRstIn),
    .laneDataIn(laneDataIn), .laneValidIn(laneValidIn),
    .laneDataOut(laneDataOut), .laneValidOut(laneValidOut),
    .syncOut(syncOut), .reinitOut(reinitOut)
  );
endmodule

// File: tb/tb_lane_sync_combiner.sv
`timescale 1ns/1ps
module tb_lane_sync_combiner;
  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0, regRdData;
  logic regWrEn = 1'b0;
  logic [3:0] laneSyncIn = '0, laneRstIn = '0;
  logic [31:0] laneDataIn = '0, laneDataOut;
  logic laneValidIn = 1'b0, laneValidOut, syncOut, reinitOut;
  int testsRun = 0, testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_sync_combiner dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  function automatic bit expSync(input int sel, input logic [3:0] s);
    case (sel)
      0: return |s;   1: return &s;
      2: return s[0] | s[1]; 3: return s[0] & s[1];
      4: return s[2] | s[3]; 5: return s[2] & s[3];
      6, 7, 8, 9: return s[sel-6];
      10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit expReinit(input int sel, input logic [3:0] r);
    case (sel)
      0: return |r;
      1: return r[0] | r[1];
      2: return r[2] | r[3];
      3, 4, 5, 6: return r[sel-3];
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(syncOut == 1'b1, "R1 syncOut", syncOut, 1);
    check(reinitOut == 1'b0, "R1 reinitOut", reinitOut, 0);
    check(laneValidOut == 1'b0 && laneDataOut == '0, "R1 lane out", laneDataOut, 0);
    rstN = 1'b1;
    rdReg(8'h0C, rd); check(rd == 8'h00, "R1 mode reset", rd, 0);
    rdReg(8'h0D, rd); check(rd == 8'h00, "R1 pol reset", rd, 0);

    // R2 mode register store/readback
    wrReg(8'h0C, 8'hB7); rdReg(8'h0C, rd); check(rd == 8'hB7, "R2 mode readback", rd, 8'hB7);
    // R3 polarity upper bits
    wrReg(8'h0D, 8'hFA); rdReg(8'h0D, rd); check(rd == 8'h0A, "R3 pol readback", rd, 8'h0A);
    // R4 unmapped
    wrReg(8'h0E, 8'h55); wrReg(8'h00, 8'h33);
    rdReg(8'h0C, rd); check(rd == 8'hB7, "R4 mode untouched", rd, 8'hB7);
    rdReg(8'h0D, rd); check(rd == 8'h0A, "R4 pol untouched", rd, 8'h0A);
    rdReg(8'h0E, rd); check(rd == 8'h00, "R4 unmapped read", rd, 0);
    wrReg(8'h0D, 8'h00);

    // R5 reinit sweep
    for (int m = 0; m < 8; m++) begin
      wrReg(8'h0C, 8'((m << 5) | 8'h10));
      for (int p = 0; p < 16; p++) begin
        laneRstIn = 4'(p);
        @(posedge clk); @(negedge clk);
        check(reinitOut == expReinit(m, 4'(p)), $sformatf("R5 mode %0d rst %0h", m, p),
              reinitOut, expReinit(m, 4'(p)));
      end
    end
    laneRstIn = '0;

    // R6/R7 sync sweep under both levels
    for (int pol = 0; pol < 2; pol++)
      for (int m = 0; m < 16; m++) begin
        wrReg(8'h0C, 8'((pol << 4) | m));
        for (int p = 0; p < 16; p++) begin
          bit e;
          laneSyncIn = 4'(p);
          e = pol ? expSync(m, 4'(p)) : !expSync(m, 4'(p));
          @(posedge clk); @(negedge clk);
          check(syncOut == e, $sformatf("R6 R7 mode %0d lvl %0d sync %0h", m, pol, p), syncOut, e);
        end
      end

    // R9 latency: output does not move before the edge
    wrReg(8'h0C, 8'h10); laneSyncIn = 4'h0;
    @(posedge clk); @(negedge clk);
    laneSyncIn = 4'h1; laneValidIn = 1'b1; #1;
    check(syncOut == 1'b0 && laneValidOut == 1'b0, "R9 before edge", {syncOut, laneValidOut}, 0);
    @(posedge clk); @(negedge clk);
    check(syncOut == 1'b1 && laneValidOut == 1'b1, "R9 after edge", {syncOut, laneValidOut}, 3);
    laneValidIn = 1'b0;
    @(posedge clk); @(negedge clk);
    check(laneValidOut == 1'b0, "R9 valid drop", laneValidOut, 0);

    // R8 lane inversion sweep
    for (int inv = 0; inv < 16; inv++) begin
      wrReg(8'h0D, 8'(inv));
      for (int k = 0; k < 3; k++) begin
        logic [31:0] d, e;
        d = 32'hA53C0F96 ^ (32'h11223344 * k);
        e = d;
        for (int ln = 0; ln < 4; ln++)
          if (inv[ln]) e[ln*8 +: 8] = ~d[ln*8 +: 8];
        laneDataIn = d; laneValidIn = k[0];
        @(posedge clk); @(negedge clk);
        check(laneDataOut == e, $sformatf("R8 inv %0h", inv), laneDataOut, e);
        check(laneValidOut == k[0], "R9 valid aligned", laneValidOut, k[0]);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule